// File: doc/BRIEF.md
# Byte Serialiser for a Peripheral Register Set

This block turns a byte written by the CPU into a clocked serial stream on two output pins: a shift clock and a serial data line. It is one unit inside a larger peripheral-interface register set. It has two registers on a small read/write port. The data register holds the byte to send. The control register holds a 3-bit mode field that picks where the shift rate comes from. The rate can be the system clock, or ticks from an external interval timer.

When a byte is written in a shift-out mode, the block sends all eight bits, most significant bit first. The data line changes only while the shift clock is low. A downstream serial-in, parallel-out register clocks each bit on the rising edge. After the eighth bit the clock stays high, the data line keeps the last bit, and an interrupt flag is raised. The flag is cleared by any read or write of the data register. A new write during a transfer restarts it with the new byte. In every other mode code, a data write only loads the register, and writing such a code during a transfer stops it.

Top module: `shout_port`

## Requirements
- R1: After reset the shift clock is high, the data line is low, the interrupt flag is low, and both registers read 0.
- R2: Address 1 is an 8-bit read/write control register. Bits 4..2 form the mode field: 110 selects shifting at the system clock, 101 selects shifting paced by `tmrTick`, and every other code disables shifting.
- R3: In mode 110, a write to the data register (address 0) at clock edge k starts an 8-bit transfer, MSB first. Bit i (i=0 is the MSB) is driven from edge k+2i. The clock is low from edge k+2i and high from edge k+2i+1.
- R4: The data line never changes while the shift clock is high. It changes only at the edge that drives the clock low.
- R5: At edge k+16 the interrupt flag rises. From then on the shift clock stays high and the data line holds the last bit sent (bit 0 of the byte). The flag is not raised at any other time.
- R6: A read or a write of the data register clears the interrupt flag at that clock edge.
- R7: After a transfer completes, reading the data register returns the byte that was written.
- R8: A data write during a transfer restarts the transfer with the new byte. No flag is raised for the abandoned byte.
- R9: In mode 101, the transfer advances by one half-bit phase only on cycles where `tmrTick` is high. It holds its clock level and data bit while `tmrTick` is low.
- R10: In a disabled mode, a data write loads the register so that it reads back. The shift clock stays high, the data line does not change, and the flag stays low.
- R11: Writing a disabled mode code during a transfer stops it. The shift clock is high from that edge on, and no flag follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (side effect: clears the flag on the data register) |
| addr | input | 2 | Register select: 0 = data, 1 = control |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data (combinational from `addr`) |
| tmrTick | input | 1 | One-cycle pace pulses for the timer-paced mode |
| sClk | output | 1 | Shift clock, idles high |
| sData | output | 1 | Serial data, MSB first |
| irqFlag | output | 1 | Shift-complete interrupt flag |

## Verification
Every output comes from a register, so a stimulus sampled at edge k first shows at the ports just after edge k. The bench drives inputs on falling edges and samples on the next falling edge. In system-clock mode it therefore reads the first bit with the clock low right after the write edge. It then sees one phase change per cycle and the flag exactly sixteen cycles after the write. It also checks that the flag is still low one cycle earlier. In timer-paced mode the bench counts `tmrTick` pulses instead of cycles. It checks that the clock level and data bit hold while no tick arrives.

// File: rtl/shout_pkg.sv
package shout_pkg;

  // Mode field placement inside the control register.
  localparam int ACR_MODE_LSB = 2;
  localparam int ACR_MODE_W   = 3;

  localparam logic [ACR_MODE_W-1:0] MODE_SYS_OUT = 3'b110;
  localparam logic [ACR_MODE_W-1:0] MODE_TMR_OUT = 3'b101;

  // Strobes from control to datapath, at most one sequencing strobe per cycle.
  typedef struct packed {
    logic load;     // capture wrData into the shift register
    logic start;    // drive MSB, clock low
    logic rise;     // clock high, data held
    logic advance;  // rotate, drive next bit, clock low
    logic finish;   // final rotate, raise flag
    logic abort;    // clock back high, no flag
    logic flagClr;  // data register accessed
  } shStrobe_t;

  function automatic logic isShiftOut(input logic [ACR_MODE_W-1:0] m);
    return (m == MODE_SYS_OUT) || (m == MODE_TMR_OUT);
  endfunction

endpackage

// File: rtl/shout_ctrl.sv
module shout_ctrl
  import shout_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataWr,
  input  logic              dataRd,
  input  logic              ctrlWr,
  input  logic [CTRL_W-1:0] wrCtrl,
  input  logic              tmrTick,
  output logic [CTRL_W-1:0] acrQ,
  output logic              busy,
  output shStrobe_t         strobe
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [ACR_MODE_W-1:0] modeQ;
  logic [ACR_MODE_W-1:0] newMode;
  logic                  phaseHigh;
  logic [CNT_W-1:0]      cntQ;
  logic                  stepEn;

  assign modeQ   = acrQ[ACR_MODE_LSB +: ACR_MODE_W];
  assign newMode = wrCtrl[ACR_MODE_LSB +: ACR_MODE_W];

  // A half-bit phase completes every cycle in system mode, on a tick in timer mode.
  assign stepEn = busy && ((modeQ == MODE_SYS_OUT) ||
                           ((modeQ == MODE_TMR_OUT) && tmrTick));

  always_comb begin
    strobe         = '0;
    strobe.load    = dataWr;
    strobe.flagClr = dataWr || dataRd;
    if (dataWr && isShiftOut(modeQ)) begin
      strobe.start = 1'b1;
    end else if (ctrlWr && busy && !isShiftOut(newMode)) begin
      strobe.abort = 1'b1;
    end else if (stepEn) begin
      if (!phaseHigh)            strobe.rise    = 1'b1;
      else if (cntQ == LAST_BIT) strobe.finish  = 1'b1;
      else                       strobe.advance = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acrQ      <= '0;
      busy      <= 1'b0;
      phaseHigh <= 1'b1;
      cntQ      <= '0;
    end else begin
      if (ctrlWr) acrQ <= wrCtrl;
      if (strobe.start) begin
        busy      <= 1'b1;
        phaseHigh <= 1'b0;
        cntQ      <= '0;
      end else if (strobe.abort || strobe.finish) begin
        busy      <= 1'b0;
        phaseHigh <= 1'b1;
      end else if (strobe.rise) begin
        phaseHigh <= 1'b1;
      end else if (strobe.advance) begin
        phaseHigh <= 1'b0;
        cntQ      <= cntQ + 1'b1;
      end
    end
  end

  // R8: a restart always begins from the first bit with the clock low
  a_r8_restart_from_msb: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && isShiftOut(modeQ)) |=> (busy && !phaseHigh && cntQ == '0));

endmodule

// File: rtl/shout_datapath.sv
module shout_datapath
  import shout_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  shStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] shRegQ,
  output logic              sClk,
  output logic              sData,
  output logic              irqFlag
);

  logic [DATA_W-1:0] rotated;
  assign rotated = {shRegQ[DATA_W-2:0], shRegQ[DATA_W-1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shRegQ  <= '0;
      sClk    <= 1'b1;
      sData   <= 1'b0;
      irqFlag <= 1'b0;
    end else begin
      // Rotating keeps the byte intact: after the last rotate it reads back whole.
      if (strobe.load)                          shRegQ <= wrData;
      else if (strobe.advance || strobe.finish) shRegQ <= rotated;

      if (strobe.start)        sData <= wrData[DATA_W-1];
      else if (strobe.advance) sData <= shRegQ[DATA_W-2];

      if (strobe.start || strobe.advance)    sClk <= 1'b0;
      else if (strobe.rise || strobe.abort)  sClk <= 1'b1;

      if (strobe.load)         irqFlag <= 1'b0;
      else if (strobe.finish)  irqFlag <= 1'b1;
      else if (strobe.flagClr) irqFlag <= 1'b0;
    end
  end

  // R4: data only moves together with a falling shift clock
  a_r4_data_stable_high: assert property (@(posedge clk) disable iff (!rstN)
    sClk |-> $stable(sData));

endmodule

// File: rtl/shout_port.sv
module shout_port
  import shout_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              tmrTick,
  output logic              sClk,
  output logic              sData,
  output logic              irqFlag
);

  localparam logic [ADDR_W-1:0] ADDR_DATA = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(1);

  logic              dataWr, dataRd, ctrlWr, busy;
  logic [DATA_W-1:0] acrQ, shRegQ;
  shStrobe_t         strobe;

  assign dataWr = wrEn && (addr == ADDR_DATA);
  assign dataRd = rdEn && (addr == ADDR_DATA);
  assign ctrlWr = wrEn && (addr == ADDR_CTRL);

  always_comb begin
    case (addr)
      ADDR_DATA: rdData = shRegQ;
      ADDR_CTRL: rdData = acrQ;
      default:   rdData = '0;
    endcase
  end

  shout_ctrl #(.DATA_W(DATA_W), .CTRL_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .dataWr(dataWr), .dataRd(dataRd),
    .ctrlWr(ctrlWr), .wrCtrl(wrData), .tmrTick(tmrTick),
    .acrQ(acrQ), .busy(busy), .strobe(strobe)
  );

  shout_datapath #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .shRegQ(shRegQ), .sClk(sClk), .sData(sData), .irqFlag(irqFlag)
  );

  logic sysMode;
  assign sysMode = (acrQ[ACR_MODE_LSB +: ACR_MODE_W] == MODE_SYS_OUT);

  // R5, R11: clock rests high whenever no transfer runs
  a_r5_idle_clk_high: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> sClk);

  // R3: in system-clock mode the shift clock flips every cycle of a transfer
  a_r3_sys_toggle: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$past(dataWr) && sysMode && $past(sysMode))
      |-> (sClk != $past(sClk)));

  // R5: the flag rises only as a transfer ends
  a_r5_flag_on_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> ($past(busy) && !busy));

  // R6: a data write leaves the flag clear
  a_r6_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    dataWr |=> !irqFlag);

endmodule

// File: tb/tb_shout_port.sv
module tb_shout_port;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0, rdEn = 1'b0, tmrTick = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       sClk, sData, irqFlag;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  shout_port dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .tmrTick(tmrTick),
    .sClk(sClk), .sData(sData), .irqFlag(irqFlag)
  );

  // {stimulus byte, expected captured stream}
  localparam int NVEC = 6;
  localparam logic [15:0] VECS [NVEC] = '{16'hA5A5, 16'h0000, 16'hFFFF,
                                          16'h5A5A, 16'h8181, 16'h3C3C};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Full system-clock transfer with per-phase checks; returns the bits seen at rising clock.
  task automatic sendSys(input logic [7:0] b, output logic [7:0] cap);
    regWrite(2'd0, b);
    for (int i = 0; i < 8; i++) begin
      chk(sClk == 1'b0, "R3 clock low phase", sClk, 0);
      chk(sData == b[7-i], "R3 bit value MSB first", sData, b[7-i]);
      @(negedge clk);
      chk(sClk == 1'b1, "R3 clock high phase", sClk, 1);
      cap[7-i] = sData;
      if (i < 7) @(negedge clk);
    end
    chk(irqFlag == 1'b0, "R5 flag not early", irqFlag, 0);
    @(negedge clk);
    chk(irqFlag == 1'b1, "R5 flag at k+16", irqFlag, 1);
    chk(sClk == 1'b1, "R5 clock idles high", sClk, 1);
    chk(sData == b[0], "R5 data holds last bit", sData, b[0]);
  endtask

  initial begin
    logic [7:0] rd, cap, held;
    rstN = 1'b0;
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(1);

    // R1 reset state
    chk(sClk == 1'b1, "R1 clock after reset", sClk, 1);
    chk(sData == 1'b0, "R1 data after reset", sData, 0);
    chk(irqFlag == 1'b0, "R1 flag after reset", irqFlag, 0);
    regRead(2'd0, rd); chk(rd == 8'h00, "R1 data register reset", rd, 0);
    regRead(2'd1, rd); chk(rd == 8'h00, "R1 control register reset", rd, 0);

    // R2 control readback and mode select (110 at bits 4..2 = 0x18)
    regWrite(2'd1, 8'h18);
    regRead(2'd1, rd); chk(rd == 8'h18, "R2 control readback", rd, 8'h18);

    // Vector table: system-clock transfers
    for (int v = 0; v < NVEC; v++) begin
      sendSys(VECS[v][15:8], cap);
      chk(cap == VECS[v][7:0], "R3 captured stream", cap, VECS[v][7:0]);
      regRead(2'd0, rd);
      chk(rd == VECS[v][15:8], "R7 readback after transfer", rd, VECS[v][15:8]);
      chk(irqFlag == 1'b0, "R6 read clears flag", irqFlag, 0);
    end

    // R6 write clears the flag
    sendSys(8'h69, cap);
    regWrite(2'd0, 8'h12);
    chk(irqFlag == 1'b0, "R6 write clears flag", irqFlag, 0);
    waitCycles(16);
    chk(irqFlag == 1'b1, "R5 flag after second transfer", irqFlag, 1);

    // R8 restart mid-transfer
    regWrite(2'd0, 8'hF0);
    waitCycles(5);
    sendSys(8'h0F, cap);
    chk(cap == 8'h0F, "R8 restarted byte", cap, 8'h0F);

    // R11 abort by writing a disabled mode
    regWrite(2'd0, 8'hAA);
    waitCycles(4);
    chk(sClk == 1'b0, "R11 mid-transfer clock low", sClk, 0);
    regWrite(2'd1, 8'h00);
    chk(sClk == 1'b1, "R11 clock high after abort", sClk, 1);
    waitCycles(20);
    chk(irqFlag == 1'b0, "R11 no flag after abort", irqFlag, 0);

    // R10 disabled mode: load only
    held = sData;
    regWrite(2'd0, 8'h96);
    for (int i = 0; i < 4; i++) begin
      chk(sClk == 1'b1, "R10 clock stays high", sClk, 1);
      chk(sData == held, "R10 data unchanged", sData, held);
      @(negedge clk);
    end
    chk(irqFlag == 1'b0, "R10 no flag", irqFlag, 0);
    regRead(2'd0, rd); chk(rd == 8'h96, "R10 register loaded", rd, 8'h96);
    regWrite(2'd1, 8'hFF);
    regRead(2'd1, rd); chk(rd == 8'hFF, "R2 full-width control readback", rd, 8'hFF);
    regWrite(2'd0, 8'h01);
    waitCycles(3);
    chk(sClk == 1'b1, "R2 code 111 disables", sClk, 1);

    // R9 timer-paced mode (101 at bits 4..2 = 0x14)
    regWrite(2'd1, 8'h14);
    regWrite(2'd0, 8'hC3);
    chk(sClk == 1'b0 && sData == 1'b1, "R9 first bit driven", {sClk, sData}, 2'b01);
    waitCycles(4);
    chk(sClk == 1'b0 && sData == 1'b1, "R9 holds without tick", {sClk, sData}, 2'b01);
    tmrTick = 1'b1;
    @(negedge clk);
    tmrTick = 1'b0;
    chk(sClk == 1'b1, "R9 tick raises clock", sClk, 1);
    waitCycles(3);
    chk(sClk == 1'b1 && irqFlag == 1'b0, "R9 high phase held", {sClk, irqFlag}, 2'b10);
    tmrTick = 1'b1;
    @(negedge clk);
    chk(sClk == 1'b0 && sData == 1'b1, "R9 second bit", {sClk, sData}, 2'b01);
    waitCycles(13);
    chk(irqFlag == 1'b0, "R9 flag not early", irqFlag, 0);
    @(negedge clk);
    tmrTick = 1'b0;
    chk(irqFlag == 1'b1, "R9 flag after 16 ticks", irqFlag, 1);
    chk(sData == 1'b1, "R9 last bit held", sData, 1);
    regRead(2'd0, rd); chk(rd == 8'hC3, "R9 readback", rd, 8'hC3);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule